// File: doc/BRIEF.md
# Overlap-Aware Memory Access Rate Monitor

This block observes activity at several levels of a memory hierarchy and measures how many accesses each level serves per busy cycle. Each level gets a group of status inputs: valid flags from the processor-side command and data buses, one valid flag per stage of the cache lookup pipeline, and a single flag that is high while the miss-tracking table is not empty. Each level also gets a one-bit access event. A level counts as busy in a cycle when any of its status inputs is high. Its busy-cycle counter then advances by one, however many accesses overlap in that cycle. For the main-memory level, the integrator ties the bus and pipeline flags low. The miss-table flag of the last-level cache and the DRAM access event are then the only inputs used.

Software controls the block through three strobes. The first is a global count enable. The second is a synchronous clear. The third is a snapshot, which copies every live counter into a shadow set in a single cycle. A selector reads the shadow pair of one level. A multi-cycle restoring divider turns the shadow pair of a chosen level into an unsigned fixed-point rate with 8 integer and 16 fractional bits. A divisor of zero is reported through a status flag.

Top module: `apc_monitor`

## Requirements
- R1: In every enabled cycle in which a level is busy, that level's busy-cycle counter rises by exactly one, whatever number of its status inputs are high.
- R2: A level is busy exactly when the OR of its bus valid flags (BUSW bits), its pipeline stage flags (PSTG bits) and its miss-table flag is 1. In a cycle with all of them 0, the busy-cycle counter does not change.
- R3: Each enabled cycle with the level's access event high adds one to that level's access counter.
- R4: Levels are independent: inputs of one level never change another level's counters. Level i uses bits [i*BUSW +: BUSW] of the bus input, bits [i*PSTG +: PSTG] of the pipeline input, and bit i of the miss-table and event inputs.
- R5: While the count enable is low, no counter changes.
- R6: Clear sets every counter to zero at the next edge, even when an increment is requested in the same cycle.
- R7: Counters stop at their all-ones value and never wrap.
- R8: A snapshot strobe copies all live counters, as they were before that edge, into the shadow set in one cycle. Without a strobe the shadow set holds its value. Shadow values are read for the level given by the read selector.
- R9: A divide request computes floor(access × 2^16 / cycles) from the shadow pair of the selected level. The result has 8 integer and 16 fractional bits. The done output is high for exactly one cycle when the result is valid.
- R10: If the shadow cycle count is zero, the result is 0, the divide-by-zero flag is 1, and done pulses on the cycle after the request.
- R11: A quotient above the largest 8.16 value gives the all-ones result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_en | input | 1 | Global count enable |
| cnt_clr | input | 1 | Synchronous clear of all live counters |
| snap_req | input | 1 | Copy live counters to the shadow set |
| bus_vld | input | NLVL*BUSW | Processor-side bus valid flags per level |
| pipe_vld | input | NLVL*PSTG | Cache pipeline stage valid flags per level |
| mshr_busy | input | NLVL | Miss-table-not-empty flag per level |
| acc_evt | input | NLVL | Access event per level |
| rd_sel | input | LVW | Level whose shadow pair is shown |
| snap_acc | output | CW | Shadow access count of the selected level |
| snap_cyc | output | CW | Shadow busy-cycle count of the selected level |
| div_start | input | 1 | Start a rate division |
| div_sel | input | LVW | Level to divide |
| apc_q | output | IBITS+FBITS | Fixed-point rate result |
| apc_done | output | 1 | One-cycle result-valid pulse |
| apc_dz | output | 1 | Last division had a zero divisor |
| apc_busy | output | 1 | Division in progress |

## Verification
Every cycle, the assertions check several counter properties. The busy-cycle counter never rises by more than one per edge. It is frozen when the level is idle or counting is disabled. Clear always yields zero. Saturating counters never go backwards. The shadow set changes only on a snapshot strobe, and then equals the live values from before the edge. The divider remainder stays below the divisor while a division runs. The exact quotient values, the saturation point, the zero-divisor result and the independence of the levels under a sweep of every status-input combination can only be shown by the bench's scenarios.

// File: rtl/apc_pkg.sv
package apc_pkg;
   typedef enum logic {DV_IDLE = 1'b0, DV_RUN = 1'b1} dv_state_e;
endpackage

// File: rtl/apc_level_counter.sv
module apc_level_counter #(
   parameter int CW       = 48,
   parameter int BUSW     = 4,
   parameter int PSTG     = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            clr,
   input  logic [BUSW-1:0] bus_vld,
   input  logic [PSTG-1:0] pipe_vld,
   input  logic            mshr_busy,
   input  logic            acc_evt,
   output logic            active,
   output logic [CW-1:0]   acc_q,
   output logic [CW-1:0]   cyc_q
);
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] acc_nx, cyc_nx;
   logic          acc_inc, cyc_inc;

   assign active  = (|bus_vld) | (|pipe_vld) | mshr_busy;
   assign acc_inc = en & acc_evt;
   assign cyc_inc = en & active;

   generate
      if (SATURATE) begin : g_sat
         assign acc_nx = (acc_inc && acc_q != CMAX) ? acc_q + 1'b1 : acc_q;
         assign cyc_nx = (cyc_inc && cyc_q != CMAX) ? cyc_q + 1'b1 : cyc_q;
      end else begin : g_wrap
         assign acc_nx = acc_q + {{(CW-1){1'b0}}, acc_inc};
         assign cyc_nx = cyc_q + {{(CW-1){1'b0}}, cyc_inc};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cyc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         cyc_q <= '0;
      end else begin
         acc_q <= acc_nx;
         cyc_q <= cyc_nx;
      end
   end

   p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (CW'(cyc_q - $past(cyc_q)) <= CW'(1)));
   p_idle_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !active) |=> $stable(cyc_q));
   p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> ($stable(acc_q) && $stable(cyc_q)));
   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0 && cyc_q == '0));

   generate
      if (SATURATE) begin : g_sat_chk
         p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (acc_q >= $past(acc_q) && cyc_q >= $past(cyc_q)));
      end
   endgenerate
endmodule

// File: rtl/apc_divider.sv
module apc_divider
   import apc_pkg::*;
#(
   parameter int NW    = 48,
   parameter int IBITS = 8,
   parameter int FBITS = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NW-1:0]          num,
   input  logic [NW-1:0]          den,
   output logic [IBITS+FBITS-1:0] res,
   output logic                   done,
   output logic                   dz,
   output logic                   busy
);
   localparam int QW  = IBITS + FBITS;
   localparam int DW  = NW + FBITS;
   localparam int KW  = $clog2(DW + 1);
   localparam logic [KW-1:0] KINIT = KW'(DW);

   dv_state_e     state;
   logic [DW-1:0] quo, quo_nx;
   logic [NW-1:0] rem, rem_nx, dvs;
   logic [NW:0]   rem_sh;
   logic [KW-1:0] cnt;
   logic [QW-1:0] res_fit;

   always_comb begin
      rem_sh = {rem, quo[DW-1]};
      if (rem_sh >= {1'b0, dvs}) begin
         rem_nx = NW'(rem_sh - {1'b0, dvs});
         quo_nx = {quo[DW-2:0], 1'b1};
      end else begin
         rem_nx = rem_sh[NW-1:0];
         quo_nx = {quo[DW-2:0], 1'b0};
      end
   end

   generate
      if (DW > QW) begin : g_clip
         assign res_fit = (|quo_nx[DW-1:QW]) ? {QW{1'b1}} : quo_nx[QW-1:0];
      end else begin : g_extend
         assign res_fit = QW'(quo_nx);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= DV_IDLE;
         quo   <= '0;
         rem   <= '0;
         dvs   <= '0;
         cnt   <= '0;
         res   <= '0;
         done  <= 1'b0;
         dz    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == DV_IDLE) begin
            if (start) begin
               if (den == '0) begin
                  res  <= '0;
                  dz   <= 1'b1;
                  done <= 1'b1;
               end else begin
                  quo   <= {num, {FBITS{1'b0}}};
                  rem   <= '0;
                  dvs   <= den;
                  cnt   <= KINIT;
                  dz    <= 1'b0;
                  state <= DV_RUN;
               end
            end
         end else begin
            quo <= quo_nx;
            rem <= rem_nx;
            cnt <= cnt - 1'b1;
            if (cnt == KW'(1)) begin
               res   <= res_fit;
               done  <= 1'b1;
               state <= DV_IDLE;
            end
         end
      end
   end

   assign busy = (state == DV_RUN);

   p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state == DV_IDLE));
   p_rem_below_divisor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DV_RUN) |-> (rem < dvs));
   p_zero_div_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dz) |-> (res == '0));
endmodule

// File: rtl/apc_monitor.sv
module apc_monitor #(
   parameter int NLVL  = 3,
   parameter int CW    = 48,
   parameter int BUSW  = 4,
   parameter int PSTG  = 4,
   parameter int IBITS = 8,
   parameter int FBITS = 16,
   parameter bit SATURATE = 1'b1,
   localparam int LVW = (NLVL > 1) ? $clog2(NLVL) : 1,
   localparam int QW  = IBITS + FBITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cnt_en,
   input  logic                 cnt_clr,
   input  logic                 snap_req,
   input  logic [NLVL*BUSW-1:0] bus_vld,
   input  logic [NLVL*PSTG-1:0] pipe_vld,
   input  logic [NLVL-1:0]      mshr_busy,
   input  logic [NLVL-1:0]      acc_evt,
   input  logic [LVW-1:0]       rd_sel,
   output logic [CW-1:0]        snap_acc,
   output logic [CW-1:0]        snap_cyc,
   input  logic                 div_start,
   input  logic [LVW-1:0]       div_sel,
   output logic [QW-1:0]        apc_q,
   output logic                 apc_done,
   output logic                 apc_dz,
   output logic                 apc_busy
);
   localparam int DETECT_BITS = NLVL * (BUSW + PSTG + 2);

   generate
      if (NLVL < 1)           begin : g_bad_nlvl $error("NLVL must be at least 1"); end
      if (CW < 2)             begin : g_bad_cw   $error("CW must be at least 2"); end
      if (BUSW < 1 || PSTG < 1) begin : g_bad_src $error("BUSW and PSTG must be at least 1"); end
      if (FBITS < 1 || IBITS < 1) begin : g_bad_fmt $error("IBITS and FBITS must be at least 1"); end
      if (DETECT_BITS > 1024) begin : g_bad_budget $error("detection state exceeds 1024 bits"); end
   endgenerate

   logic [CW-1:0] live_acc [NLVL];
   logic [CW-1:0] live_cyc [NLVL];
   logic [CW-1:0] sh_acc   [NLVL];
   logic [CW-1:0] sh_cyc   [NLVL];
   logic [NLVL-1:0] lvl_active;

   generate
      for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
         apc_level_counter #(
            .CW(CW), .BUSW(BUSW), .PSTG(PSTG), .SATURATE(SATURATE)
         ) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cnt_en),
            .clr      (cnt_clr),
            .bus_vld  (bus_vld[gi*BUSW +: BUSW]),
            .pipe_vld (pipe_vld[gi*PSTG +: PSTG]),
            .mshr_busy(mshr_busy[gi]),
            .acc_evt  (acc_evt[gi]),
            .active   (lvl_active[gi]),
            .acc_q    (live_acc[gi]),
            .cyc_q    (live_cyc[gi])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_acc[gi] <= '0;
               sh_cyc[gi] <= '0;
            end else if (snap_req) begin
               sh_acc[gi] <= live_acc[gi];
               sh_cyc[gi] <= live_cyc[gi];
            end
         end

         p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
            snap_req |=> (sh_acc[gi] == $past(live_acc[gi]) && sh_cyc[gi] == $past(live_cyc[gi])));
         p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !snap_req |=> ($stable(sh_acc[gi]) && $stable(sh_cyc[gi])));
      end
   endgenerate

   logic [CW-1:0] div_num, div_den;

   always_comb begin
      snap_acc = '0;
      snap_cyc = '0;
      div_num  = '0;
      div_den  = '0;
      for (int k = 0; k < NLVL; k++) begin
         if (rd_sel == LVW'(k)) begin
            snap_acc = sh_acc[k];
            snap_cyc = sh_cyc[k];
         end
         if (div_sel == LVW'(k)) begin
            div_num = sh_acc[k];
            div_den = sh_cyc[k];
         end
      end
   end

   apc_divider #(.NW(CW), .IBITS(IBITS), .FBITS(FBITS)) i_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(div_start),
      .num  (div_num),
      .den  (div_den),
      .res  (apc_q),
      .done (apc_done),
      .dz   (apc_dz),
      .busy (apc_busy)
   );
endmodule

// File: tb/test_apc_monitor.sv
module test_apc_monitor;
   localparam int NL = 3, CW = 10, BW = 2, PS = 3, IB = 8, FB = 16;
   localparam int LVW = 2, QW = IB + FB;
   localparam int CMAX = (1 << CW) - 1;
   localparam longint QMAX = (64'd1 << QW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cnt_en = 0, cnt_clr = 0, snap_req = 0, div_start = 0;
   logic [NL*BW-1:0] bus_vld = '0;
   logic [NL*PS-1:0] pipe_vld = '0;
   logic [NL-1:0] mshr_busy = '0, acc_evt = '0;
   logic [LVW-1:0] rd_sel = '0, div_sel = '0;
   logic [CW-1:0] snap_acc, snap_cyc;
   logic [QW-1:0] apc_q;
   logic apc_done, apc_dz, apc_busy;

   apc_monitor #(.NLVL(NL), .CW(CW), .BUSW(BW), .PSTG(PS), .IBITS(IB), .FBITS(FB)) i_apc_monitor (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .snap_req(snap_req),
      .bus_vld(bus_vld), .pipe_vld(pipe_vld), .mshr_busy(mshr_busy), .acc_evt(acc_evt),
      .rd_sel(rd_sel), .snap_acc(snap_acc), .snap_cyc(snap_cyc), .div_start(div_start),
      .div_sel(div_sel), .apc_q(apc_q), .apc_done(apc_done), .apc_dz(apc_dz), .apc_busy(apc_busy));

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int m_acc [NL], m_cyc [NL], s_acc [NL], s_cyc [NL];
   logic t_en, t_clr, t_snap, t_start;
   logic [LVW-1:0] t_sel;
   logic [NL*BW-1:0] t_bus;
   logic [NL*PS-1:0] t_pipe;
   logic [NL-1:0] t_mshr, t_evt;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_fields();
      t_en = 0; t_clr = 0; t_snap = 0; t_start = 0; t_sel = '0;
      t_bus = '0; t_pipe = '0; t_mshr = '0; t_evt = '0;
   endtask

   // one clock of stimulus; the model computes what the edge will do
   task automatic tick();
      @(negedge clk);
      cnt_en = t_en; cnt_clr = t_clr; snap_req = t_snap; div_start = t_start;
      div_sel = t_sel; bus_vld = t_bus; pipe_vld = t_pipe; mshr_busy = t_mshr; acc_evt = t_evt;
      for (int l = 0; l < NL; l++) begin
         logic act;
         act = (|t_bus[l*BW +: BW]) | (|t_pipe[l*PS +: PS]) | t_mshr[l];
         if (t_snap) begin s_acc[l] = m_acc[l]; s_cyc[l] = m_cyc[l]; end
         if (t_clr) begin m_acc[l] = 0; m_cyc[l] = 0; end
         else if (t_en) begin
            if (t_evt[l] && m_acc[l] < CMAX) m_acc[l]++;
            if (act && m_cyc[l] < CMAX) m_cyc[l]++;
         end
      end
      @(posedge clk);
      #1;
      cnt_en = 0; cnt_clr = 0; snap_req = 0; div_start = 0;
      bus_vld = '0; pipe_vld = '0; mshr_busy = '0; acc_evt = '0;
      idle_fields();
   endtask

   task automatic snap_tick();
      idle_fields(); t_snap = 1; tick();
   endtask

   task automatic check_shadow(input string req);
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
         rd_sel = LVW'(l);
         #1;
         chk(req, snap_acc, s_acc[l]);
         chk(req, snap_cyc, s_cyc[l]);
      end
   endtask

   task automatic load_level(input int l, input int a, input int c);
      idle_fields(); t_clr = 1; tick();
      for (int i = 0; i < (a > c ? a : c); i++) begin
         idle_fields(); t_en = 1;
         if (i < c) t_mshr[l] = 1'b1;
         if (i < a) t_evt[l] = 1'b1;
         tick();
      end
      snap_tick();
   endtask

   task automatic divide_check(input int l, input string req);
      longint exp;
      int waited;
      bit got;
      exp = (s_cyc[l] == 0) ? 0 : ((longint'(s_acc[l]) << FB) / s_cyc[l]);
      if (exp > QMAX) exp = QMAX;
      idle_fields(); t_start = 1; t_sel = LVW'(l); tick();
      got = 0; waited = 0;
      while (!got && waited < 100) begin
         @(negedge clk);
         if (apc_done) got = 1; else waited++;
      end
      chk({req, " done seen"}, got, 1);
      chk(req, apc_q, exp);
      chk({req, " dz flag"}, apc_dz, (s_cyc[l] == 0));
      @(negedge clk);
      chk("R9 done one cycle", apc_done, 0);
   endtask

   initial begin
      #3_000_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int l = 0; l < NL; l++) begin m_acc[l] = 0; m_cyc[l] = 0; s_acc[l] = 0; s_cyc[l] = 0; end
      idle_fields();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("reset done low", apc_done, 0);
      chk("reset busy low", apc_busy, 0);
      snap_tick(); check_shadow("reset R8 zero");

      // R1 R2 R3 R4: every source combination on each level in turn
      for (int l = 0; l < NL; l++) begin
         for (int p = 0; p < 64; p++) begin
            idle_fields(); t_en = 1;
            t_bus[l*BW +: BW] = p[1:0];
            t_pipe[l*PS +: PS] = p[4:2];
            t_mshr[l] = p[5];
            t_evt[l] = p[0] ^ p[3];
            tick();
            snap_tick();
            @(negedge clk);
            rd_sel = LVW'(l); #1;
            chk("R1 R2 busy cycles", snap_cyc, s_cyc[l]);
            chk("R3 accesses", snap_acc, s_acc[l]);
         end
         check_shadow("R4 other levels");
      end

      // R5: enable low, all inputs active
      idle_fields(); t_bus = '1; t_pipe = '1; t_mshr = '1; t_evt = '1; tick();
      snap_tick(); check_shadow("R5 disabled");

      // R8: snapshot in a counting cycle takes pre-edge values, then holds
      idle_fields(); t_en = 1; t_snap = 1; t_mshr = '1; t_evt = '1; tick();
      check_shadow("R8 pre-edge copy");
      idle_fields(); t_en = 1; t_mshr = '1; tick();
      check_shadow("R8 hold");
      snap_tick(); check_shadow("R8 refresh");

      // R6: clear beats increment
      idle_fields(); t_en = 1; t_clr = 1; t_bus = '1; t_mshr = '1; t_evt = '1; tick();
      snap_tick(); check_shadow("R6 clear wins");

      // R7: saturation on level 0
      for (int i = 0; i < CMAX + 8; i++) begin
         idle_fields(); t_en = 1; t_pipe[0] = 1'b1; t_evt[0] = 1'b1; tick();
      end
      snap_tick(); check_shadow("R7 saturate");

      // R9 R10 R11: divisions on several levels and ratios
      load_level(1, 5, 7);    divide_check(1, "R9 5/7");
      load_level(2, 1, 1);    divide_check(2, "R9 1/1");
      load_level(0, 3, 1000); divide_check(0, "R9 3/1000");
      load_level(1, 0, 4);    divide_check(1, "R9 0/4");
      load_level(0, 255, 1);  divide_check(0, "R9 255/1");
      load_level(2, 4, 0);    divide_check(2, "R10 zero divisor");
      load_level(1, 256, 1);  divide_check(1, "R11 256/1 clips");
      load_level(0, 600, 2);  divide_check(0, "R11 600/2 clips");
      load_level(2, 1023, 1023); divide_check(2, "R9 full/full");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule